// File: doc/BRIEF.md
# Serial Display Command/Data Link Master

This block is the master side of a serial link to a display controller. It drives an active-low chip select, a mode-0 serial clock, a serial output line and a command/data level line. It samples a serial input line for read responses. A transaction is requested in one handshake that carries the following fields:

- an optional command byte;
- a payload byte count;
- a read byte count;
- the link style: 3-wire, where the command/data flag is sent in-band as a ninth bit, or 4-wire, where the flag is carried on the separate level line;
- the unit width: 8 or 16 bits.

Payload bytes then arrive on a valid/ready stream. Read bytes come back as single-cycle strobes.

Each transaction runs in a fixed order: the command first, then the payload, then the read phase. Chip select stays low from the first clock edge to the last. In 16-bit width, bytes are widened to words. A pixel stream with no command is packed two bytes per word, high byte first. A separate request starts a display reset pulse whose length in clock cycles is given with the request.

Top module: `disp_serial_master`

## Requirements
- R1: In 3-wire mode every unit is 9 bits, sent most significant bit first. The first bit is the flag: it is the inverse of `DATA_FLAG` for the command word and equal to `DATA_FLAG` (default 1) for each payload byte. The flag is followed by the byte, MSB first.
- R2: The serial clock idles low. It toggles only while chip select is low. The output bit is stable at each rising edge, and each clock half-period lasts `CLK_DIV` system cycles.
- R3: In 4-wire 8-bit mode the command byte is sent as 8 bits with `disp_dc` at 0, and each payload byte is sent as 8 bits with `disp_dc` at 1.
- R4: In 4-wire 16-bit mode with a command, the command and every payload byte are each sent as a 16-bit word whose upper byte is zero.
- R5: A transaction with a command and no payload or read bytes sends only the command. `disp_dc` is not raised and stays at 0 after completion.
- R6: In 4-wire 16-bit mode without a command, payload bytes form 16-bit words with the earlier byte in the upper half. A final odd byte is sent as a word with 0x00 first and the byte second.
- R7: In 4-wire reads, chip select stays low for the whole transaction. The command goes out with `disp_dc` at 0. Each read byte is clocked in over 8 clock edges with `disp_dc` at 1, MSB first, and is presented on `rd_data` with a one-cycle `rd_valid`.
- R8: In 3-wire reads, the command goes out as a 9-bit word. The response is then clocked in as plain 8-bit units with no flag bit.
- R9: A request for 3-wire mode with 16-bit width, or a request with no command, no payload and no read bytes, is rejected. The block pulses `err` for one cycle, and chip select and the serial clock do not move.
- R10: `disp_rst` is 0 out of reset. A reset request with a non-zero length N raises it for exactly N cycles, starting the cycle after the request. A request while the pulse is running is ignored, and a request with length 0 is ignored.
- R11: Each accepted transaction ends with a one-cycle `done` pulse in the same cycle that chip select returns high. Chip select never rises at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_mode4 | input | 1 | 1: 4-wire (separate command/data line), 0: 3-wire (in-band flag) |
| req_wide | input | 1 | 1: 16-bit units, 0: 8-bit units |
| req_has_cmd | input | 1 | A command byte leads the transaction |
| req_cmd | input | 8 | Command byte |
| req_wr_len | input | LEN_W | Payload byte count |
| req_rd_len | input | LEN_W | Read byte count |
| pay_valid | input | 1 | Payload byte valid |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Payload byte taken when valid |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transaction complete pulse |
| err | output | 1 | Request rejected pulse |
| rst_req | input | 1 | Start a display reset pulse |
| rst_cycles | input | RST_W | Reset pulse length in cycles |
| disp_rst | output | 1 | Display reset, active high |
| disp_csn | output | 1 | Chip select, active low |
| disp_sclk | output | 1 | Serial clock |
| disp_mosi | output | 1 | Serial output |
| disp_miso | input | 1 | Serial input |
| disp_dc | output | 1 | Command (0) / data (1) line |

## Verification
The bench builds the block with `CLK_DIV` = 3, which selects the counter variant of the clock divider rather than the pass-through variant. At that setting each bit spans six cycles, so the output bit can be sampled well clear of any edge. `LEN_W` = 8 and `RST_W` = 8 keep the odd-byte packing, multi-byte reads and a short reset pulse within a few hundred cycles. `DATA_FLAG` is left at 1, so the command word carries a leading 0 and payload bytes a leading 1. A serial slave model in the bench replays response bits by clock-edge index, which lets both read styles be checked against known bytes.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_PAY,
      ST_READ,
      ST_WAIT,
      ST_FIN
   } seq_state_e;

   typedef struct packed {
      logic [15:0] word;
      logic [4:0]  nbits;
   } unit_t;

   localparam logic [4:0] BITS_NARROW = 5'd8;
   localparam logic [4:0] BITS_FLAGGED = 5'd9;
   localparam logic [4:0] BITS_WIDE = 5'd16;

endpackage

// File: rtl/disp_tick.sv
module disp_tick #(
   parameter int CLK_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   if (CLK_DIV < 1) begin : g_bad_div
      $error("disp_tick: CLK_DIV must be at least 1");
   end

   if (CLK_DIV == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (!run || cnt == LAST) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign tick = run && (cnt == LAST);
   end

endmodule

// File: rtl/disp_shift.sv
module disp_shift
   import disp_ser_pkg::*;
#(
   parameter int CLK_DIV = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  unit_t      unit,
   input  logic       miso,
   output logic       busy,
   output logic       done,
   output logic       sclk,
   output logic       mosi,
   output logic [7:0] rx_byte
);

   logic [15:0] sh;
   logic [4:0]  left;
   logic        high_phase;
   logic        tick;

   disp_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh         <= '0;
         left       <= '0;
         high_phase <= 1'b0;
         busy       <= 1'b0;
         done       <= 1'b0;
         sclk       <= 1'b0;
         rx_byte    <= '0;
      end else begin
         done <= 1'b0;
         if (load && !busy) begin
            sh         <= unit.word << (5'd16 - unit.nbits);
            left       <= unit.nbits;
            high_phase <= 1'b0;
            busy       <= 1'b1;
         end else if (busy && tick) begin
            if (!high_phase) begin
               sclk       <= 1'b1;
               rx_byte    <= {rx_byte[6:0], miso};
               high_phase <= 1'b1;
            end else begin
               sclk       <= 1'b0;
               high_phase <= 1'b0;
               if (left == 5'd1) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  sh   <= sh << 1;
                  left <= left - 1'b1;
               end
            end
         end
      end
   end

   assign mosi = sh[15];

endmodule

// File: rtl/disp_rst_pulse.sv
module disp_rst_pulse #(
   parameter int RST_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [RST_W-1:0] cycles,
   output logic             rst_out
);

   logic [RST_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end else if (req) begin
         remain <= cycles;
      end
   end

   assign rst_out = (remain != '0);

endmodule

// File: rtl/disp_serial_master.sv
module disp_serial_master
   import disp_ser_pkg::*;
#(
   parameter int   CLK_DIV   = 3,
   parameter int   LEN_W     = 8,
   parameter int   RST_W     = 8,
   parameter logic DATA_FLAG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_mode4,
   input  logic             req_wide,
   input  logic             req_has_cmd,
   input  logic [7:0]       req_cmd,
   input  logic [LEN_W-1:0] req_wr_len,
   input  logic [LEN_W-1:0] req_rd_len,
   input  logic             pay_valid,
   input  logic [7:0]       pay_data,
   output logic             pay_ready,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic             err,
   input  logic             rst_req,
   input  logic [RST_W-1:0] rst_cycles,
   output logic             disp_rst,
   output logic             disp_csn,
   output logic             disp_sclk,
   output logic             disp_mosi,
   input  logic             disp_miso,
   output logic             disp_dc
);

   if (LEN_W < 2) begin : g_bad_len
      $error("disp_serial_master: LEN_W must be at least 2");
   end
   if (RST_W < 1) begin : g_bad_rst
      $error("disp_serial_master: RST_W must be at least 1");
   end

   localparam logic CMD_FLAG = ~DATA_FLAG;
   localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

   seq_state_e       st, nxt;
   logic             m4_q, wide_q, hc_q;
   logic [7:0]       cmd_q, hi_q;
   logic             have_hi, is_rd;
   logic [LEN_W-1:0] wrem, rrem;
   logic             dc_q, csn_q, done_q, err_q, rdv_q;
   logic [7:0]       rdd_q;

   logic             bad_req, pair_mode, hold_first;
   logic             load;
   unit_t            cmd_unit, pay_unit, rd_unit, unit;
   logic             sh_busy, sh_done;
   logic [7:0]       sh_rx;

   assign req_ready  = (st == ST_IDLE);
   assign pay_ready  = (st == ST_PAY);
   assign bad_req    = (!req_mode4 && req_wide) ||
                       (!req_has_cmd && req_wr_len == '0 && req_rd_len == '0);
   assign pair_mode  = m4_q && wide_q && !hc_q;
   assign hold_first = pair_mode && !have_hi && (wrem >= TWO);

   always_comb begin
      if (!m4_q) begin
         cmd_unit = '{word: {7'd0, CMD_FLAG, cmd_q}, nbits: BITS_FLAGGED};
         pay_unit = '{word: {7'd0, DATA_FLAG, pay_data}, nbits: BITS_FLAGGED};
      end else if (wide_q) begin
         cmd_unit = '{word: {8'h00, cmd_q}, nbits: BITS_WIDE};
         pay_unit = '{word: {(have_hi ? hi_q : 8'h00), pay_data}, nbits: BITS_WIDE};
      end else begin
         cmd_unit = '{word: {8'h00, cmd_q}, nbits: BITS_NARROW};
         pay_unit = '{word: {8'h00, pay_data}, nbits: BITS_NARROW};
      end
      rd_unit = '{word: 16'h0000, nbits: BITS_NARROW};
   end

   always_comb begin
      unique case (st)
         ST_CMD:  begin load = 1'b1;                      unit = cmd_unit; end
         ST_PAY:  begin load = pay_valid && !hold_first;  unit = pay_unit; end
         ST_READ: begin load = 1'b1;                      unit = rd_unit;  end
         default: begin load = 1'b0;                      unit = rd_unit;  end
      endcase
   end

   always_comb begin
      if (wrem != '0) begin
         nxt = ST_PAY;
      end else if (rrem != '0) begin
         nxt = ST_READ;
      end else begin
         nxt = ST_FIN;
      end
   end

   disp_shift #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .unit   (unit),
      .miso   (disp_miso),
      .busy   (sh_busy),
      .done   (sh_done),
      .sclk   (disp_sclk),
      .mosi   (disp_mosi),
      .rx_byte(sh_rx)
   );

   disp_rst_pulse #(.RST_W(RST_W)) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (rst_req),
      .cycles (rst_cycles),
      .rst_out(disp_rst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         m4_q    <= 1'b0;
         wide_q  <= 1'b0;
         hc_q    <= 1'b0;
         cmd_q   <= '0;
         hi_q    <= '0;
         have_hi <= 1'b0;
         is_rd   <= 1'b0;
         wrem    <= '0;
         rrem    <= '0;
         dc_q    <= 1'b1;
         csn_q   <= 1'b1;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdv_q   <= 1'b0;
         rdd_q   <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rdv_q  <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  if (bad_req) begin
                     err_q <= 1'b1;
                  end else begin
                     m4_q    <= req_mode4;
                     wide_q  <= req_wide;
                     hc_q    <= req_has_cmd;
                     cmd_q   <= req_cmd;
                     wrem    <= req_wr_len;
                     rrem    <= req_rd_len;
                     have_hi <= 1'b0;
                     csn_q   <= 1'b0;
                     if (req_has_cmd)            st <= ST_CMD;
                     else if (req_wr_len != '0)  st <= ST_PAY;
                     else                        st <= ST_READ;
                  end
               end
            end
            ST_CMD: begin
               if (m4_q) dc_q <= 1'b0;
               is_rd <= 1'b0;
               st    <= ST_WAIT;
            end
            ST_PAY: begin
               if (pay_valid) begin
                  wrem <= wrem - 1'b1;
                  if (hold_first) begin
                     hi_q    <= pay_data;
                     have_hi <= 1'b1;
                  end else begin
                     have_hi <= 1'b0;
                     is_rd   <= 1'b0;
                     if (m4_q) dc_q <= 1'b1;
                     st <= ST_WAIT;
                  end
               end
            end
            ST_READ: begin
               rrem  <= rrem - 1'b1;
               is_rd <= 1'b1;
               if (m4_q) dc_q <= 1'b1;
               st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (sh_done) begin
                  if (is_rd) begin
                     rdv_q <= 1'b1;
                     rdd_q <= sh_rx;
                  end
                  st <= nxt;
               end
            end
            ST_FIN: begin
               csn_q  <= 1'b1;
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign disp_csn = csn_q;
   assign disp_dc  = dc_q;
   assign done     = done_q;
   assign err      = err_q;
   assign rd_valid = rdv_q;
   assign rd_data  = rdd_q;

endmodule

// File: rtl/disp_serial_master_chk.sv
module disp_serial_master_chk (
   input logic clk,
   input logic rst_n,
   input logic disp_csn,
   input logic disp_sclk,
   input logic done,
   input logic err,
   input logic rst_req,
   input logic disp_rst,
   input logic pay_ready
);

   p_sclk_under_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_sclk |-> !disp_csn);

   p_reject_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (disp_csn && !disp_sclk));

   p_done_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(disp_csn));

   p_cs_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_csn) |-> done);

   p_rst_from_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_rst) |-> $past(rst_req));

   p_pay_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pay_ready |-> !disp_csn);

endmodule

bind disp_serial_master disp_serial_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .disp_csn (disp_csn),
   .disp_sclk(disp_sclk),
   .done     (done),
   .err      (err),
   .rst_req  (rst_req),
   .disp_rst (disp_rst),
   .pay_ready(pay_ready)
);

// File: tb/sim_disp_serial_master.sv
module sim_disp_serial_master;

   localparam int PERIOD = 10;
   localparam int LEN_W = 8;
   localparam int RST_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic             req_mode4 = 1'b0;
   logic             req_wide = 1'b0;
   logic             req_has_cmd = 1'b0;
   logic [7:0]       req_cmd = '0;
   logic [LEN_W-1:0] req_wr_len = '0;
   logic [LEN_W-1:0] req_rd_len = '0;
   logic             pay_valid = 1'b0;
   logic [7:0]       pay_data = '0;
   logic             pay_ready;
   logic             rd_valid;
   logic [7:0]       rd_data;
   logic             done, err;
   logic             rst_req = 1'b0;
   logic [RST_W-1:0] rst_cycles = '0;
   logic             disp_rst, disp_csn, disp_sclk, disp_mosi, disp_miso, disp_dc;

   always #(PERIOD/2) clk = ~clk;

   disp_serial_master #(.CLK_DIV(3), .LEN_W(LEN_W), .RST_W(RST_W), .DATA_FLAG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_mode4(req_mode4),
      .req_wide(req_wide), .req_has_cmd(req_has_cmd), .req_cmd(req_cmd),
      .req_wr_len(req_wr_len), .req_rd_len(req_rd_len),
      .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
      .rst_req(rst_req), .rst_cycles(rst_cycles), .disp_rst(disp_rst),
      .disp_csn(disp_csn), .disp_sclk(disp_sclk), .disp_mosi(disp_mosi),
      .disp_miso(disp_miso), .disp_dc(disp_dc)
   );

   int n_checks = 0;
   int n_fails = 0;

   // bus monitor state
   int          cap_n = 0;
   logic [255:0] cap_bits = '0;
   logic [255:0] cap_dc = '0;
   logic [255:0] rsp_bits = '0;
   int          sclk_bad = 0;
   int          csn_rise = 0;
   int          csn_fall = 0;
   int          done_cnt = 0;
   int          err_cnt = 0;
   int          rd_n = 0;
   logic [7:0]  rd_buf [0:7];
   logic [7:0]  pay_arr [0:7];
   int          exp_n = 0;
   logic [255:0] exp_bits = '0;
   logic [255:0] exp_dc = '0;

   assign disp_miso = rsp_bits[cap_n[7:0]];

   always @(posedge disp_sclk) begin
      if (disp_csn) sclk_bad++;
      cap_bits[cap_n[7:0]] = disp_mosi;
      cap_dc[cap_n[7:0]]   = disp_dc;
      cap_n++;
   end
   always @(posedge disp_csn) csn_rise++;
   always @(negedge disp_csn) csn_fall++;
   always @(posedge clk) begin
      if (done) done_cnt++;
      if (err)  err_cnt++;
      if (rd_valid && rd_n < 8) begin
         rd_buf[rd_n] = rd_data;
         rd_n++;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(negedge clk);
      cap_n = 0; cap_bits = '0; cap_dc = '0; rsp_bits = '0;
      sclk_bad = 0; csn_rise = 0; csn_fall = 0; rd_n = 0;
      exp_n = 0; exp_bits = '0; exp_dc = '0;
   endtask

   task automatic push_unit(input logic [15:0] w, input int nb, input logic dcv);
      for (int j = nb - 1; j >= 0; j--) begin
         exp_bits[exp_n[7:0]] = w[j];
         exp_dc[exp_n[7:0]]   = dcv;
         exp_n++;
      end
   endtask

   task automatic put_rsp(input int off, input logic [7:0] b);
      for (int j = 0; j < 8; j++) rsp_bits[off + j] = b[7 - j];
   endtask

   task automatic cmp_stream(input string tag, input bit use_dc);
      int bad_at;
      bad_at = -1;
      check({tag, " bit count"}, cap_n, exp_n);
      for (int i = 0; i < exp_n; i++) begin
         if (bad_at < 0 && (cap_bits[i] !== exp_bits[i] || (use_dc && cap_dc[i] !== exp_dc[i])))
            bad_at = i;
      end
      check({tag, " first mismatching bit"}, bad_at, -1);
   endtask

   task automatic feed(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         pay_valid = 1'b1;
         pay_data  = pay_arr[k];
         while (!pay_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk);
      pay_valid = 1'b0;
   endtask

   task automatic run(input bit m4, input bit wide, input bit hc, input logic [7:0] c,
                      input int wl, input int rl, input int nfeed);
      int d0, e0, t;
      d0 = done_cnt;
      e0 = err_cnt;
      @(negedge clk);
      req_mode4 = m4; req_wide = wide; req_has_cmd = hc; req_cmd = c;
      req_wr_len = LEN_W'(wl); req_rd_len = LEN_W'(rl);
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      fork
         feed(nfeed);
         begin
            t = 0;
            while (done_cnt == d0 && err_cnt == e0 && t < 5000) begin
               @(negedge clk);
               t++;
            end
         end
      join
      repeat (4) @(negedge clk);
      check("R11 transaction ended before timeout", (t < 5000), 1);
   endtask

   task automatic t_reset_state();
      check("R10 reset output idle after power-up", disp_rst, 0);
      check("R2 chip select idle high", disp_csn, 1);
      check("R2 serial clock idle low", disp_sclk, 0);
      check("R11 no done at reset", done, 0);
      check("R9 no err at reset", err, 0);
   endtask

   task automatic t_three_wire_write();
      int d0;
      clear_mon();
      d0 = done_cnt;
      pay_arr[0] = 8'hA5; pay_arr[1] = 8'h3C;
      push_unit({7'd0, 1'b0, 8'h2A}, 9, 1'b0);
      push_unit({7'd0, 1'b1, 8'hA5}, 9, 1'b0);
      push_unit({7'd0, 1'b1, 8'h3C}, 9, 1'b0);
      run(1'b0, 1'b0, 1'b1, 8'h2A, 2, 0, 2);
      cmp_stream("R1 3-wire flagged words", 1'b0);
      check("R11 one done pulse", done_cnt - d0, 1);
      check("R2 no clock edge outside chip select", sclk_bad, 0);
   endtask

   task automatic t_four_wire_narrow();
      clear_mon();
      pay_arr[0] = 8'h11; pay_arr[1] = 8'h80; pay_arr[2] = 8'hFF;
      push_unit(16'h0036, 8, 1'b0);
      push_unit(16'h0011, 8, 1'b1);
      push_unit(16'h0080, 8, 1'b1);
      push_unit(16'h00FF, 8, 1'b1);
      run(1'b1, 1'b0, 1'b1, 8'h36, 3, 0, 3);
      cmp_stream("R3 4-wire 8-bit with dc level", 1'b1);
      check("R11 chip select released once", csn_rise, 1);
   endtask

   task automatic t_cmd_only();
      clear_mon();
      push_unit(16'h0001, 8, 1'b0);
      run(1'b1, 1'b0, 1'b1, 8'h01, 0, 0, 0);
      cmp_stream("R5 command alone", 1'b1);
      check("R5 dc stays low after command-only", disp_dc, 0);
   endtask

   task automatic t_wide_cmd();
      clear_mon();
      pay_arr[0] = 8'h05; pay_arr[1] = 8'h3A;
      push_unit(16'h00B1, 16, 1'b0);
      push_unit(16'h0005, 16, 1'b1);
      push_unit(16'h003A, 16, 1'b1);
      run(1'b1, 1'b1, 1'b1, 8'hB1, 2, 0, 2);
      cmp_stream("R4 16-bit zero-extended command and parameters", 1'b1);
   endtask

   task automatic t_wide_stream();
      clear_mon();
      pay_arr[0] = 8'hF8; pay_arr[1] = 8'h1F; pay_arr[2] = 8'hC3;
      push_unit(16'hF81F, 16, 1'b1);
      push_unit(16'h00C3, 16, 1'b1);
      run(1'b1, 1'b1, 1'b0, 8'h00, 3, 0, 3);
      cmp_stream("R6 paired stream with odd tail", 1'b1);
   endtask

   task automatic t_four_wire_read();
      clear_mon();
      put_rsp(8, 8'h9D);
      put_rsp(16, 8'h42);
      push_unit(16'h0004, 8, 1'b0);
      push_unit(16'h0000, 8, 1'b1);
      push_unit(16'h0000, 8, 1'b1);
      run(1'b1, 1'b0, 1'b1, 8'h04, 0, 2, 0);
      cmp_stream("R7 4-wire read framing and dc", 1'b1);
      check("R7 chip select held through read", csn_rise, 1);
      check("R7 read byte count", rd_n, 2);
      check("R7 first read byte", rd_buf[0], 8'h9D);
      check("R7 second read byte", rd_buf[1], 8'h42);
   endtask

   task automatic t_three_wire_read();
      clear_mon();
      put_rsp(9, 8'h5E);
      push_unit({7'd0, 1'b0, 8'h0A}, 9, 1'b0);
      push_unit(16'h0000, 8, 1'b0);
      run(1'b0, 1'b0, 1'b1, 8'h0A, 0, 1, 0);
      cmp_stream("R8 3-wire read 9-bit command then 8-bit response", 1'b0);
      check("R8 read byte count", rd_n, 1);
      check("R8 read byte value", rd_buf[0], 8'h5E);
   endtask

   task automatic t_reject();
      int e0, d0;
      clear_mon();
      e0 = err_cnt; d0 = done_cnt;
      run(1'b0, 1'b1, 1'b1, 8'h2C, 2, 0, 0);
      check("R9 3-wire 16-bit rejected", err_cnt - e0, 1);
      run(1'b1, 1'b0, 1'b0, 8'h00, 0, 0, 0);
      check("R9 empty request rejected", err_cnt - e0, 2);
      check("R9 no done on reject", done_cnt - d0, 0);
      check("R9 no clock edges on reject", cap_n, 0);
      check("R9 chip select untouched on reject", csn_fall, 0);
   endtask

   task automatic t_reset_pulse();
      int hi;
      hi = 0;
      @(negedge clk);
      rst_req = 1'b1; rst_cycles = RST_W'(5);
      @(negedge clk);
      rst_req = 1'b0;
      if (disp_rst) hi++;
      @(negedge clk);
      if (disp_rst) hi++;
      rst_req = 1'b1; rst_cycles = RST_W'(9);
      @(negedge clk);
      rst_req = 1'b0;
      if (disp_rst) hi++;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (disp_rst) hi++;
      end
      check("R10 reset pulse length, retrigger ignored", hi, 5);
      hi = 0;
      @(negedge clk);
      rst_req = 1'b1; rst_cycles = '0;
      @(negedge clk);
      rst_req = 1'b0;
      for (int k = 0; k < 5; k++) begin
         if (disp_rst) hi++;
         @(negedge clk);
      end
      check("R10 zero-length request ignored", hi, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      t_three_wire_write();
      t_four_wire_narrow();
      t_cmd_only();
      t_wide_cmd();
      t_wide_stream();
      t_four_wire_read();
      t_three_wire_read();
      t_reject();
      t_reset_pulse();
      $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
      $finish;
   end

endmodule